// File: doc/BRIEF.md
# Transmit Minimum-Length Pad and FCS Stage

This stage sits on the transmit path between a frame producer and the line-side logic of an Ethernet MAC. Frames arrive one byte per cycle on a valid/ready stream, with a start marker on the first byte and an end marker on the last. The stage passes the payload through without adding latency. When the frame ends, it adds zero bytes and then a 32-bit frame check sequence, as the frame needs.

Each frame brings two control flags, both active high: `in_skip_pad` and `in_skip_fcs`. They are sampled only on the byte that carries the start marker. A frame whose payload is shorter than the minimum frame length minus four is padded with 0x00 up to that length, unless padding is disabled for it. A padded frame always gets the check sequence, whatever the skip-FCS flag says. A frame that is not padded gets the check sequence only when the skip-FCS flag is clear. While pad or check bytes are being sent, the input is held off.

Top module: `tx_pad_crc`

## Requirements
- R1: Payload bytes leave in order and unchanged, with no added latency. `out_sof` is high only on the first output byte of a frame.
- R2: If `in_skip_pad` is 0 and the payload is shorter than MIN_FRAME-4 bytes (60 by default), the payload is followed by 0x00 bytes until it is MIN_FRAME-4 bytes long.
- R3: If `in_skip_pad` is 1, no pad bytes are added, whatever the payload length.
- R4: A frame that was padded under R2 also gets the 4-byte check sequence, even when `in_skip_fcs` is 1.
- R5: A frame that is not padded gets the check sequence exactly when `in_skip_fcs` is 0. A payload of exactly MIN_FRAME-4 bytes with padding enabled gets no pad bytes.
- R6: The check sequence is the reflected CRC-32: polynomial 0x04C11DB7, initial value 0xFFFFFFFF, final inversion. It is computed over the payload and the pad bytes and sent least significant byte first. For the payload "123456789" the four bytes are 0x26, 0x39, 0xF4, 0xCB.
- R7: Both flags are taken from the beat that carries `in_sof`. Their values on the other beats of the frame have no effect.
- R8: While pad or check bytes are being sent, `in_ready` is low. When `out_ready` is low, these bytes hold their value until they are accepted.
- R9: `out_eof` is high on the last output byte of a frame only: the last check byte, the last pad byte never, or the last payload byte when nothing is appended.
- R10: Reset is asynchronous and active low. During and after reset, no tail is pending: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input payload byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_skip_pad | input | 1 | Disable padding (sampled with in_sof) |
| in_skip_fcs | input | 1 | Disable check sequence for unpadded frames (sampled with in_sof) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted when high with out_valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of frame |
| out_eof | output | 1 | Last output byte of frame |

## Verification
The bench builds the stage with the default MIN_FRAME of 64, so the pad target is 60. The payload lengths 59, 60 and 61 therefore fall on either side of the pad threshold, and a single-byte frame produces the longest pad run. The stimulus table pairs each length with the flag combinations and drives the inverse flag values on every non-first beat, so that any sampling of a later beat changes the output. It also switches output backpressure and input gaps on and off. A directed frame checks the CRC against the well-known "123456789" check value, and a reset applied during padding checks that the pending tail is dropped.

// File: rtl/tx_pad_crc.sv
module tx_pad_crc #(
  parameter int MIN_FRAME = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_skip_pad,
  input  logic       in_skip_fcs,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  localparam int PAD_TO = MIN_FRAME - 4;
  localparam int CNT_W  = $clog2(PAD_TO + 1);
  localparam logic [CNT_W-1:0] PAD_C = CNT_W'(PAD_TO);

  typedef enum logic [1:0] {S_PASS = 2'd0, S_PAD = 2'd1, S_FCS = 2'd2} state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  state_t           state;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      crc_q;
  logic             skip_pad_q, skip_fcs_q;
  logic [1:0]       fcs_idx;

  logic             skip_pad_eff, skip_fcs_eff;
  logic [CNT_W-1:0] cnt_base, cnt_inc;
  logic [31:0]      crc_base, fcs;
  logic             pass_fire, short_end, fcs_end;

  assign skip_pad_eff = in_sof ? in_skip_pad : skip_pad_q;
  assign skip_fcs_eff = in_sof ? in_skip_fcs : skip_fcs_q;
  assign cnt_base     = in_sof ? '0 : cnt_q;
  assign cnt_inc      = (cnt_base == PAD_C) ? cnt_base : cnt_base + 1'b1;
  assign crc_base     = in_sof ? 32'hFFFF_FFFF : crc_q;
  assign short_end    = !skip_pad_eff && (cnt_inc != PAD_C);
  assign fcs_end      = short_end || !skip_fcs_eff;
  assign pass_fire    = (state == S_PASS) && in_valid && out_ready;
  assign fcs          = ~crc_q;

  assign in_ready  = (state == S_PASS) && out_ready;
  assign out_valid = (state == S_PASS) ? in_valid : 1'b1;
  assign out_sof   = (state == S_PASS) && in_sof;

  always_comb begin
    case (state)
      S_PAD:   begin out_data = 8'h00;               out_eof = 1'b0;              end
      S_FCS:   begin out_data = fcs[8*fcs_idx +: 8]; out_eof = (fcs_idx == 2'd3); end
      default: begin out_data = in_data;             out_eof = in_eof && !fcs_end; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_PASS;
      cnt_q      <= '0;
      crc_q      <= 32'hFFFF_FFFF;
      skip_pad_q <= 1'b0;
      skip_fcs_q <= 1'b0;
      fcs_idx    <= 2'd0;
    end else begin
      case (state)
        S_PASS: if (pass_fire) begin
          crc_q      <= crc_step(crc_base, in_data);
          cnt_q      <= cnt_inc;
          skip_pad_q <= skip_pad_eff;
          skip_fcs_q <= skip_fcs_eff;
          fcs_idx    <= 2'd0;
          if (in_eof) begin
            if (short_end)    state <= S_PAD;
            else if (fcs_end) state <= S_FCS;
          end
        end
        S_PAD: if (out_ready) begin
          crc_q <= crc_step(crc_q, 8'h00);
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == PAD_C - 1'b1) state <= S_FCS;
        end
        S_FCS: if (out_ready) begin
          fcs_idx <= fcs_idx + 1'b1;
          if (fcs_idx == 2'd3) state <= S_PASS;
        end
        default: state <= S_PASS;
      endcase
    end
  end
endmodule

// File: rtl/tx_pad_crc_chk.sv
module tx_pad_crc_chk #(
  parameter int MIN_FRAME = 64,
  parameter int CNT_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic [1:0]       st,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] PAD_C = CNT_W'(MIN_FRAME - 4);

  assert_no_accept_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |-> !in_ready);

  assert_hold_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0 && out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

  assert_sof_head_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (st == 2'd0));

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && out_valid) |-> (out_data == 8'h00 && !out_eof));

  assert_pad_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && $past(st) == 2'd1) |-> (cnt == PAD_C));

  assert_eof_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof) |=> (st == 2'd0));
endmodule

bind tx_pad_crc tx_pad_crc_chk #(.MIN_FRAME(MIN_FRAME), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
  .st(state), .cnt(cnt_q)
);

// File: tb/tx_pad_crc_bench.sv
module tx_pad_crc_bench;
  localparam int MINF  = 64;
  localparam int PADTO = MINF - 4;
  localparam int NV    = 11;
  // columns: payload length, skip_pad, skip_fcs, expected output length
  localparam int TV_LEN [NV] = '{1, 5, 59, 60, 61, 60, 30, 30, 70, 2, 59};
  localparam int TV_NP  [NV] = '{0, 0, 0,  0,  0,  0,  1,  1,  1,  0, 1};
  localparam int TV_NC  [NV] = '{0, 1, 0,  0,  0,  1,  0,  1,  1,  1, 0};
  localparam int TV_OUT [NV] = '{64,64,64, 64, 65, 60, 34, 30, 70, 64, 63};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, in_sof = 0, in_eof = 0, in_skip_pad = 0, in_skip_fcs = 0;
  logic [7:0] in_data = 8'h00, out_data;
  logic out_valid, out_ready = 1'b1, out_sof, out_eof;

  always #5 clk = ~clk;

  tx_pad_crc #(.MIN_FRAME(MINF)) u_tx_pad_crc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_skip_pad(in_skip_pad), .in_skip_fcs(in_skip_fcs),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof));

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] pl [256];
  logic [7:0] got [256];
  logic gsof [256], geof [256];
  int ngot;
  logic [7:0] expb [256];
  int nexp;
  bit tail_bad;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, expb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic run_frame(input int len, input bit np, input bit nc, input bit stall, input bit gap);
    int idx = 0, guard = 0;
    bit done = 0, pend = 0;
    ngot = 0; tail_bad = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (!pend) begin
        if (idx < len && (!gap || cyc % 4 != 1)) begin
          in_valid = 1; in_data = pl[idx];
          in_sof = (idx == 0); in_eof = (idx == len - 1);
          in_skip_pad = (idx == 0) ? np : !np;   // R7: later beats carry inverted flags
          in_skip_fcs = (idx == 0) ? nc : !nc;
        end else in_valid = 0;
      end
      #1;
      if (idx == len && out_valid && in_ready) tail_bad = 1;
      if (in_valid && in_ready) begin idx++; pend = 0; end else pend = in_valid;
      if (out_valid && out_ready && ngot < 256) begin
        got[ngot] = out_data; gsof[ngot] = out_sof; geof[ngot] = out_eof;
        ngot++;
        if (out_eof) done = 1;
      end
      guard++;
    end
    in_valid = 0;
    chk(done, "R9", "frame end seen", int'(done), 1);
  endtask

  task automatic check_frame(input int len, input bit np, input bit nc, input int exp_len);
    bit padded;
    int bad = -1;
    logic [31:0] crc;
    string tag;
    padded = !np && (len < PADTO);
    nexp = 0;
    for (int i = 0; i < len; i++) expb[nexp++] = pl[i];
    if (padded) while (nexp < PADTO) expb[nexp++] = 8'h00;
    if (padded || !nc) begin
      crc = ref_crc(nexp);
      for (int k = 0; k < 4; k++) expb[nexp++] = crc[8*k +: 8];
    end
    tag = padded ? "R2/R4" : (np ? "R3" : "R5");
    chk(ngot == exp_len && nexp == exp_len, tag, "output length", ngot, exp_len);
    for (int i = 0; i < nexp && i < ngot; i++)
      if (bad < 0 && got[i] !== expb[i]) bad = i;
    chk(bad < 0, "R1/R6", "byte content", bad < 0 ? 0 : int'(got[bad]), bad < 0 ? 0 : int'(expb[bad]));
    bad = -1;
    for (int i = 0; i < ngot; i++)
      if (bad < 0 && (gsof[i] !== (i == 0) || geof[i] !== (i == ngot - 1))) bad = i;
    chk(bad < 0, "R9", "sof/eof marker position", bad, -1);
    if (ngot > len) chk(!tail_bad, "R8", "in_ready low during tail", int'(tail_bad), 0);
  endtask

  initial begin
    // R10: reset state
    out_ready = 1; #12;
    chk(out_valid == 0, "R10", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1, "R10", "in_ready follows out_ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1;
    @(negedge clk); out_ready = 0; #1;
    chk(in_ready == 0, "R10", "in_ready follows out_ready low", int'(in_ready), 0);
    out_ready = 1;

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < TV_LEN[v]; i++) pl[i] = 8'(i * 13 + v * 7 + 1);
      run_frame(TV_LEN[v], TV_NP[v] != 0, TV_NC[v] != 0, v % 2 == 1, v % 3 == 0);
      check_frame(TV_LEN[v], TV_NP[v] != 0, TV_NC[v] != 0, TV_OUT[v]);
    end

    // R6: known check value, no padding
    for (int i = 0; i < 9; i++) pl[i] = 8'h31 + 8'(i);
    run_frame(9, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(ngot == 13, "R6", "check frame length", ngot, 13);
    chk(got[9]  == 8'h26, "R6", "fcs byte 0", int'(got[9]),  'h26);
    chk(got[10] == 8'h39, "R6", "fcs byte 1", int'(got[10]), 'h39);
    chk(got[11] == 8'hF4, "R6", "fcs byte 2", int'(got[11]), 'hF4);
    chk(got[12] == 8'hCB, "R6", "fcs byte 3", int'(got[12]), 'hCB);

    // R8/R10: reset while padding
    @(negedge clk);
    out_ready = 1; in_valid = 1; in_sof = 1; in_eof = 1; in_data = 8'hAA;
    in_skip_pad = 0; in_skip_fcs = 0;
    @(negedge clk); in_valid = 0; out_ready = 0; #1;
    chk(out_valid == 1 && out_data == 8'h00, "R2", "pad byte after short frame", int'(out_data), 0);
    chk(in_ready == 0, "R8", "input held off while pad pending", int'(in_ready), 0);
    @(negedge clk); #1;
    chk(out_valid == 1 && out_data == 8'h00, "R8", "pad held under backpressure", int'(out_valid), 1);
    rst_n = 0; out_ready = 1; #1;
    chk(out_valid == 0 && in_ready == 1, "R10", "tail dropped by reset", int'(out_valid), 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 4; i++) pl[i] = 8'hF0 + 8'(i);
    run_frame(4, 1'b0, 1'b1, 1'b0, 1'b0);
    check_frame(4, 1'b0, 1'b1, 64);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule